// File: doc/BRIEF.md
# Bus Cycle Single-Step Controller

This block lets an operator halt a processor bus and advance it one bus cycle at a time. It drives the bus ready line. When ready is high, bus cycles proceed. When ready is low, the current cycle stalls in a wait state. A run/stop level selects free running or stepping. In stepping mode, every cycle-start strobe arms an internal wait flag, and the wait flag pulls ready low. The flag drops only on a fresh press of a changeover push button. One press therefore lets exactly one bus cycle complete. The next cycle-start strobe arms the flag again.

The two raw contacts of the step button feed a set/reset latch, and this latch removes contact bounce. All asynchronous inputs pass through two register stages on the system clock. The rising edge of the latch output produces a single-clock clear request. The cycle-start strobe takes priority over that clear request. Open-collector drive is modelled as a plain active-high ready output, and a running indicator mirrors it.

Top module: `busStepCtrl`

## Requirements
- R1: After reset the wait flag is 0, the step latch is 0 (released) and ready is 1.
- R2: While the synchronised run/stop level is 0 (run), ready is 1 whatever the wait flag holds.
- R3: While the synchronised run/stop level is 1 (stop), ready equals the inverse of the wait flag.
- R4: Every input passes through two clock stages. A cycle-start strobe that is high after those stages sets the wait flag on the next edge, so the flag is visible three edges after the strobe is applied.
- R5: A rising edge of the step latch clears the wait flag once. Holding the button, releasing it, or repeating strobes while it is held never clear the flag again. One press lets exactly one strobe-to-strobe cycle through.
- R6: The step latch is set when the press contact (active low) reads 0 and the release contact (active low) reads 1. It is cleared in the opposite case. It holds its state when both contacts read 0 or both read 1.
- R7: When the strobe is high in the same clock as a clear request, the wait flag stays set.
- R8: The running indicator always equals ready.
- R9: The wait flag is set by the strobe in run mode as well, and it is visible on the debug output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycStartIn | input | 1 | Bus cycle-start strobe, active high |
| stopIn | input | 1 | Run/stop level, 1 = stop/step mode |
| pressContactN | input | 1 | Step button press contact, active low |
| releaseContactN | input | 1 | Step button release contact, active low |
| readyOut | output | 1 | Bus ready line, 1 = cycle may proceed |
| runningOut | output | 1 | Running indicator, equal to ready |
| stepLatchOut | output | 1 | Debounced step latch state |
| waitFlagOut | output | 1 | Wait flag state |

## Verification
The directed patterns have separate purposes. Strobes in run mode show that the flag is armed but ready stays high. A clean press after a strobe in stop mode shows that exactly one cycle is released. Holding the button across a second strobe, and then releasing it, shows that neither action releases another cycle. Contact states with both contacts open or both closed show that the latch holds its state instead of producing a false step. A press while the strobe is held high shows that the strobe wins. Random contact bounce, strobes and mode flips are then compared every clock against a bench reference. These patterns expose a wrong synchroniser depth, a wrong latch polarity and a level-triggered clear.

// File: rtl/busStepPkg.sv
package busStepPkg;
  localparam int SYNC_STAGES = 2;

  // Index of each input bit inside the synchroniser vector
  localparam int IDX_CYC   = 0;
  localparam int IDX_STOP  = 1;
  localparam int IDX_PRESS = 2;
  localparam int IDX_REL   = 3;
  localparam int IN_WIDTH  = 4;

  // Idle values: strobe low, run, button resting on its release throw
  localparam logic [IN_WIDTH-1:0] IN_IDLE = 4'b0100;

  typedef struct packed {
    logic setWait;
    logic clrWait;
  } stepStrobe_t;
endpackage

// File: rtl/busStepSync.sv
module busStepSync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= RESET_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/busStepControl.sv
module busStepControl
  import busStepPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycStartSync,
  input  logic        pressSyncN,
  input  logic        releaseSyncN,
  output stepStrobe_t strobes,
  output logic        stepLatch
);
  logic latchPrev;

  // Debounce latch: set/reset with active-low inputs; hold on both or none
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepLatch <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      latchPrev <= stepLatch;
      case ({pressSyncN, releaseSyncN})
        2'b01:   stepLatch <= 1'b1;
        2'b10:   stepLatch <= 1'b0;
        default: stepLatch <= stepLatch;
      endcase
    end
  end

  always_comb begin
    strobes.setWait = cycStartSync;
    strobes.clrWait = stepLatch & ~latchPrev;
  end

  // R6
  latch_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pressSyncN && releaseSyncN) |=> stepLatch);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pressSyncN == releaseSyncN) |=> $stable(stepLatch));
  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrWait |=> !strobes.clrWait);
endmodule

// File: rtl/busStepDatapath.sv
module busStepDatapath
  import busStepPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stepStrobe_t strobes,
  input  logic        stopSync,
  output logic        waitFlag,
  output logic        ready
);
  // Preset (strobe) dominates the clocked clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitFlag <= 1'b0;
    else if (strobes.setWait) waitFlag <= 1'b1;
    else if (strobes.clrWait) waitFlag <= 1'b0;
  end

  assign ready = ~(stopSync & waitFlag);

  // R4
  set_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setWait |=> waitFlag);
  // R7
  set_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setWait && strobes.clrWait) |=> waitFlag);
  // R5
  clear_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrWait && !strobes.setWait) |=> !waitFlag);
  // R5
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitFlag && !strobes.clrWait) |=> waitFlag);
endmodule

// File: rtl/busStepCtrl.sv
module busStepCtrl
  import busStepPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cycStartIn,
  input  logic stopIn,
  input  logic pressContactN,
  input  logic releaseContactN,
  output logic readyOut,
  output logic runningOut,
  output logic stepLatchOut,
  output logic waitFlagOut
);
  logic [IN_WIDTH-1:0] rawIn;
  logic [IN_WIDTH-1:0] syncIn;
  stepStrobe_t         strobes;
  logic                stepLatch;
  logic                waitFlag;
  logic                ready;

  always_comb begin
    rawIn            = '0;
    rawIn[IDX_CYC]   = cycStartIn;
    rawIn[IDX_STOP]  = stopIn;
    rawIn[IDX_PRESS] = pressContactN;
    rawIn[IDX_REL]   = releaseContactN;
  end

  busStepSync #(
    .WIDTH(IN_WIDTH), .STAGES(SYNC_STAGES), .RESET_VAL(IN_IDLE)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  busStepControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cycStartSync(syncIn[IDX_CYC]),
    .pressSyncN(syncIn[IDX_PRESS]),
    .releaseSyncN(syncIn[IDX_REL]),
    .strobes(strobes),
    .stepLatch(stepLatch)
  );

  busStepDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .stopSync(syncIn[IDX_STOP]),
    .waitFlag(waitFlag), .ready(ready)
  );

  assign readyOut     = ready;
  assign runningOut   = ready;
  assign stepLatchOut = stepLatch;
  assign waitFlagOut  = waitFlag;

  // R2
  run_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syncIn[IDX_STOP]) |-> readyOut);
  // R3
  stall_only_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut) |-> waitFlagOut);
  // R8
  running_chk: assert property (@(posedge clk) disable iff (!rstN)
    runningOut == readyOut);
endmodule

// File: tb/busStepCtrl_bench.sv
module busStepCtrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycStartIn = 1'b0, stopIn = 1'b0;
  logic pressContactN = 1'b1, releaseContactN = 1'b0;
  logic readyOut, runningOut, stepLatchOut, waitFlagOut;
  int errors = 0, checks = 0;
  bit doneRun = 0;

  always #2 clk = ~clk;

  busStepCtrl u_busStepCtrl (
    .clk(clk), .rstN(rstN), .cycStartIn(cycStartIn), .stopIn(stopIn),
    .pressContactN(pressContactN), .releaseContactN(releaseContactN),
    .readyOut(readyOut), .runningOut(runningOut),
    .stepLatchOut(stepLatchOut), .waitFlagOut(waitFlagOut)
  );

  // Reference built from the requirements: two input stages, then latch, flag
  logic [3:0] m1, m2;
  logic mLatch, mPrev, mFlag;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 4'b0100; m2 <= 4'b0100;
      mLatch <= 1'b0; mPrev <= 1'b0; mFlag <= 1'b0;
    end else begin
      m1 <= {releaseContactN, pressContactN, stopIn, cycStartIn};
      m2 <= m1;
      mPrev <= mLatch;
      if (!m2[2] && m2[3]) mLatch <= 1'b1;
      else if (m2[2] && !m2[3]) mLatch <= 1'b0;
      if (m2[0]) mFlag <= 1'b1;
      else if (mLatch && !mPrev) mFlag <= 1'b0;
    end
  end

  function automatic logic expReady(input logic stopS, input logic flag);
    return !(stopS && flag);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStrobe();
    cycStartIn = 1'b1; cyc(1); cycStartIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneRun) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3); rstN = 1'b1; cyc(1);
    check("R1 ready", readyOut, 1'b1);
    check("R1 wait", waitFlagOut, 1'b0);
    check("R1 latch", stepLatchOut, 1'b0);

    // Run mode: flag arms, ready stays high
    pulseStrobe(); cyc(4);
    check("R9 flag armed in run", waitFlagOut, 1'b1);
    check("R2 ready in run", readyOut, 1'b1);
    check("R8 running", runningOut, 1'b1);
    pressContactN = 0; releaseContactN = 1; cyc(5);
    check("R6 latch set", stepLatchOut, 1'b1);
    check("R5 flag cleared", waitFlagOut, 1'b0);
    pressContactN = 1; releaseContactN = 0; cyc(5);
    check("R6 latch cleared", stepLatchOut, 1'b0);

    // Stop mode
    stopIn = 1; cyc(3);
    check("R3 ready no wait", readyOut, 1'b1);
    pulseStrobe(); cyc(1);
    check("R4 not yet after two stages", waitFlagOut, 1'b0);
    cyc(2);
    check("R4 flag set third edge", waitFlagOut, 1'b1);
    check("R3 ready low", readyOut, 1'b0);
    check("R8 running low", runningOut, 1'b0);
    releaseContactN = 1; cyc(5);     // both open
    check("R6 hold both open", stepLatchOut, 1'b0);
    check("R5 no release by bounce", readyOut, 1'b0);
    pressContactN = 0; releaseContactN = 0; cyc(5);  // both closed
    check("R6 hold both closed", stepLatchOut, 1'b0);
    releaseContactN = 1; cyc(5);     // clean press
    check("R5 press releases cycle", readyOut, 1'b1);
    pulseStrobe(); cyc(4);
    check("R5 next strobe stalls", readyOut, 1'b0);
    cyc(10);
    check("R5 held button no second step", readyOut, 1'b0);
    pressContactN = 1; releaseContactN = 0; cyc(6);
    check("R5 release does not step", readyOut, 1'b0);

    // Strobe held high across a press
    cycStartIn = 1; cyc(2);
    pressContactN = 0; releaseContactN = 1; cyc(8);
    check("R7 strobe wins", waitFlagOut, 1'b1);
    cycStartIn = 0; cyc(6);
    check("R7 stays set after edge passed", readyOut, 1'b0);
    pressContactN = 1; releaseContactN = 0; cyc(5);
    pressContactN = 0; releaseContactN = 1; cyc(5);
    check("R5 fresh press steps", readyOut, 1'b1);
    pulseStrobe(); cyc(4);
    stopIn = 0; cyc(3);
    check("R2 run forces ready", readyOut, 1'b1);

    // Random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      int r;
      check("R3 R2 ready random", readyOut, expReady(m2[1], mFlag));
      check("R5 R4 flag random", waitFlagOut, mFlag);
      check("R6 latch random", stepLatchOut, mLatch);
      check("R8 running random", runningOut, readyOut);
      r = int'($urandom_range(0, 99));
      cycStartIn = (r < 12);
      if ($urandom_range(0, 99) < 3) stopIn = ~stopIn;
      r = int'($urandom_range(0, 99));
      if (r < 6)       begin pressContactN = 0; releaseContactN = 1; end
      else if (r < 12) begin pressContactN = 1; releaseContactN = 0; end
      else if (r < 15) begin pressContactN = 1; releaseContactN = 1; end
      else if (r < 17) begin pressContactN = 0; releaseContactN = 0; end
      cyc(1);
    end
    doneRun = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule